// File: doc/BRIEF.md
# Byte-Addressed I2C Register Access Engine

This block is the bus-facing end of a small register bank. It watches the serial clock and data lines of a two-wire bus through synchronisers clocked by a fast system clock, detects START and STOP conditions, and responds only to its own 7-bit device address. A write transfer first sets an internal byte pointer and then delivers data bytes to a register file through a one-cycle write strobe. A read transfer streams bytes back from that pointer. The pointer advances after every data byte and wraps around at the top of the 17-byte space.

The lowest bytes of the space belong to a running time counter that lives outside the block. Reads of those bytes never see the live counter. They see a copy taken on every START (including a repeated one), on every STOP, and whenever the pointer steps back to address 00h. A multi-byte read therefore returns one coherent time value even while the counter keeps ticking. The other bytes come straight from the register file's read port. If the clock line stays low for too long in the middle of a transfer, the engine drops the transfer and waits for a fresh START.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The engine acknowledges, by pulling SDA low on the ninth clock, only an address byte whose upper seven bits equal DEV_ADDR (default 1101000b). Bit 0 selects the direction: 0 for write, 1 for read. For any other address, that byte and every later byte up to the next START or STOP get no acknowledge, no write strobe and no SDA drive.
- R2: In a write transfer, the first byte after the address is acknowledged and loads the pointer. A value above 10h loads 00h.
- R3: Each later write byte, received MSB first, is acknowledged. When its acknowledge begins, the engine issues exactly one write strobe carrying the current pointer and the byte. The pointer then increments.
- R4: In both reads and writes, the pointer steps from 10h to 00h. The register address never leaves the range 00h to 10h.
- R5: A read transfer that has no pointer write before it starts at the pointer left by the previous access. It sends bytes MSB first and increments the pointer after each byte.
- R6: Read bytes at addresses 07h to 10h come from the register file's read port at the current pointer.
- R7: Read bytes at addresses 00h to 06h come from a time snapshot. The snapshot is captured on START, on repeated START, on STOP, and whenever the pointer increments to 00h.
- R8: When the master answers a read byte with NACK, the engine releases SDA and drives nothing more until the next START.
- R9: If SCL stays low for TIMEOUT_CYC system clocks while a transfer is in progress, the engine returns to idle, releases SDA, and ignores all traffic until a new START.
- R10: During and after reset, SDA is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line level |
| sda_in | input | 1 | Raw serial data line level |
| sda_pull | output | 1 | 1 pulls the open-drain data line low |
| live_time | input | TIME_BYTES*8 | Running time bytes; byte i occupies bits [8i+7:8i] |
| reg_addr | output | $clog2(NREGS) | Current pointer, used as the register file read address |
| reg_rdata | input | 8 | Register file byte at reg_addr |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | $clog2(NREGS) | Write address that goes with wr_en |
| wr_data | output | 8 | Write data that goes with wr_en |

## Verification
The hardest case to reach from the ports is a snapshot taken on pointer wrap, as distinct from one taken on START. The wrap happens while the byte at 10h is being loaded, only a few SCL periods after the START, so the two captures are close together in time. The stimulus sets the pointer to 10h and issues a repeated START. It then changes the live time before the read address byte is sent, and expects the byte read at 00h to show the new value rather than the value present at the START. The timeout is reached by lowering the bench parameter and holding SCL low in the middle of a write transfer. Bytes sent afterwards must get no acknowledge and no write strobe.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RX   = 3'd1,
        PH_ACK  = 3'd2,
        PH_TX   = 3'd3,
        PH_MACK = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        BY_ADDR = 2'd0,
        BY_PTR  = 2'd1,
        BY_DATA = 2'd2
    } bkind_e;
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '1;
        end else begin
            chain_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_rb_cond.sv
module i2c_rb_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rb_snap.sv
module i2c_rb_snap #(
    parameter int BYTES = 7,
    parameter int AW    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap,
    input  logic [BYTES*8-1:0]    live,
    input  logic [AW-1:0]         idx,
    output logic [7:0]            rd_byte
);
    logic [7:0] hold_q [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   hold_q[g] <= '0;
            else if (cap) hold_q[g] <= live[g*8 +: 8];
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (idx == AW'(i)) rd_byte = hold_q[i];
        end
    end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101000,
    parameter int         NREGS       = 17,
    parameter int         TIME_BYTES  = 7,
    parameter int         SYNC_STAGES = 2,
    parameter int         TIMEOUT_CYC = 3_500_000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_pull,
    input  logic [TIME_BYTES*8-1:0]    live_time,
    output logic [$clog2(NREGS)-1:0]   reg_addr,
    input  logic [7:0]                 reg_rdata,
    output logic                       wr_en,
    output logic [$clog2(NREGS)-1:0]   wr_addr,
    output logic [7:0]                 wr_data
);
    localparam int AW   = $clog2(NREGS);
    localparam int TW   = $clog2(TIMEOUT_CYC + 1);
    localparam int LAST = NREGS - 1;

    typedef struct packed {
        phase_e              ph;
        bkind_e              kind;
        logic                rd;
        logic [3:0]          cnt;
        logic [BYTE_W-1:0]   sh;
        logic [AW-1:0]       ptr;
        logic                pull;
        logic                mack;
        logic                wr_en;
        logic [AW-1:0]       wr_addr;
        logic [BYTE_W-1:0]   wr_data;
        logic [TW-1:0]       tcnt;
    } state_t;

    state_t st_d, st_q;

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_evt, stop_evt;
    logic wrap_now, snap_cap, engaged, to_hit;
    logic [AW-1:0] ptr_inc;
    logic [7:0] snap_byte, tx_byte;

    i2c_rb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .d_out ({scl_s, sda_s})
    );

    i2c_rb_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    assign snap_cap = start_evt | stop_evt | wrap_now;

    i2c_rb_snap #(.BYTES(TIME_BYTES), .AW(AW)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (snap_cap),
        .live    (live_time),
        .idx     (st_q.ptr),
        .rd_byte (snap_byte)
    );

    assign ptr_inc = (st_q.ptr == AW'(LAST)) ? '0 : st_q.ptr + 1'b1;
    assign tx_byte = (st_q.ptr < AW'(TIME_BYTES)) ? snap_byte : reg_rdata;
    assign engaged = (st_q.ph != PH_IDLE);
    assign to_hit  = engaged && !scl_s && (st_q.tcnt == TW'(TIMEOUT_CYC));

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        wrap_now   = 1'b0;
        st_d.tcnt  = (engaged && !scl_s) ? st_q.tcnt + 1'b1 : '0;

        if (start_evt) begin
            st_d.ph   = PH_RX;
            st_d.kind = BY_ADDR;
            st_d.cnt  = '0;
            st_d.pull = 1'b0;
            st_d.tcnt = '0;
        end else if (stop_evt || to_hit) begin
            st_d.ph   = PH_IDLE;
            st_d.pull = 1'b0;
            st_d.tcnt = '0;
        end else begin
            unique case (st_q.ph)
                PH_RX: begin
                    if (scl_rise && st_q.cnt < 4'd8) begin
                        st_d.sh  = {st_q.sh[BYTE_W-2:0], sda_s};
                        st_d.cnt = st_q.cnt + 4'd1;
                    end else if (scl_fall && st_q.cnt == 4'd8) begin
                        unique case (st_q.kind)
                            BY_ADDR: begin
                                if (st_q.sh[7:1] == DEV_ADDR) begin
                                    st_d.rd   = st_q.sh[0];
                                    st_d.kind = BY_PTR;
                                    st_d.ph   = PH_ACK;
                                    st_d.pull = 1'b1;
                                end else begin
                                    st_d.ph = PH_IDLE;
                                end
                            end
                            BY_PTR: begin
                                st_d.ptr  = (st_q.sh > BYTE_W'(LAST)) ? '0 : st_q.sh[AW-1:0];
                                st_d.kind = BY_DATA;
                                st_d.ph   = PH_ACK;
                                st_d.pull = 1'b1;
                            end
                            default: begin
                                st_d.wr_en   = 1'b1;
                                st_d.wr_addr = st_q.ptr;
                                st_d.wr_data = st_q.sh;
                                st_d.ptr     = ptr_inc;
                                wrap_now     = (st_q.ptr == AW'(LAST));
                                st_d.ph      = PH_ACK;
                                st_d.pull    = 1'b1;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        st_d.cnt = '0;
                        if (st_q.rd) begin
                            st_d.sh   = tx_byte;
                            st_d.pull = ~tx_byte[7];
                            st_d.ptr  = ptr_inc;
                            wrap_now  = (st_q.ptr == AW'(LAST));
                            st_d.ph   = PH_TX;
                        end else begin
                            st_d.pull = 1'b0;
                            st_d.ph   = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_rise && st_q.cnt < 4'd8) begin
                        st_d.cnt = st_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (st_q.cnt == 4'd8) begin
                            st_d.pull = 1'b0;
                            st_d.ph   = PH_MACK;
                        end else begin
                            st_d.sh   = {st_q.sh[BYTE_W-2:0], 1'b0};
                            st_d.pull = ~st_q.sh[6];
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) begin
                        st_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (st_q.mack) begin
                            st_d.cnt  = '0;
                            st_d.sh   = tx_byte;
                            st_d.pull = ~tx_byte[7];
                            st_d.ptr  = ptr_inc;
                            wrap_now  = (st_q.ptr == AW'(LAST));
                            st_d.ph   = PH_TX;
                        end else begin
                            st_d.ph = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sda_pull = st_q.pull;
    assign reg_addr = st_q.ptr;
    assign wr_en    = st_q.wr_en;
    assign wr_addr  = st_q.wr_addr;
    assign wr_data  = st_q.wr_data;
endmodule

// File: rtl/i2c_rb_checker.sv
module i2c_rb_checker #(
    parameter int NREGS = 17
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sda_pull,
    input logic                     wr_en,
    input logic [$clog2(NREGS)-1:0] wr_addr,
    input logic [$clog2(NREGS)-1:0] reg_addr,
    input logic                     start_evt,
    input logic                     stop_evt
);
    localparam int AW = $clog2(NREGS);

    // R4: write addresses stay inside the register space
    assert_wr_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr <= AW'(NREGS - 1)));

    // R4: pointer never leaves the register space
    assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr <= AW'(NREGS - 1));

    // R3: a write strobe lasts one cycle
    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R3: a write strobe coincides with the start of the acknowledge
    assert_strobe_with_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_pull);

    // R8: after STOP the data line is released
    assert_release_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull);

    // R1: START begins an address phase with the line released
    assert_release_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_pull);
endmodule

bind i2c_regbank_slave i2c_rb_checker #(.NREGS(NREGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_pull  (sda_pull),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .reg_addr  (reg_addr),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
);

// File: tb/test_i2c_regbank_slave.sv
`timescale 1ns/1ps
module test_i2c_regbank_slave;
    localparam int NREGS = 17;
    localparam int TB    = 7;
    localparam int TO    = 400;
    localparam int HP    = 10;
    localparam int AW    = $clog2(NREGS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull, wr_en;
    logic sda_bus;
    logic [TB*8-1:0] live = '0;
    logic [AW-1:0] reg_addr, wr_addr;
    logic [7:0] reg_rdata, wr_data;
    logic [7:0] mem [NREGS];
    logic [7:0] exp_mem [NREGS];
    int errors = 0;
    int checks = 0;
    int wr_count = 0;
    int ptr_m = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_pull;
    assign reg_rdata = mem[reg_addr];

    i2c_regbank_slave #(.NREGS(NREGS), .TIME_BYTES(TB), .TIMEOUT_CYC(TO)) i_i2c_regbank_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_bus),
        .sda_pull  (sda_pull),
        .live_time (live),
        .reg_addr  (reg_addr),
        .reg_rdata (reg_rdata),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    always @(posedge clk) begin
        if (rst_n && wr_en) begin
            mem[wr_addr] <= wr_data;
            wr_count <= wr_count + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] live_byte(input int seed, input int i);
        return 8'(seed * 13 + i * 29 + 1);
    endfunction

    task automatic set_live(input int seed);
        for (int i = 0; i < TB; i++) live[i*8 +: 8] = live_byte(seed, i);
    endtask

    function automatic int nxt(input int p);
        return (p == NREGS - 1) ? 0 : p + 1;
    endfunction

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
        end
        sda_m = 1'b1; hp(); scl_m = 1'b1;
        repeat (HP / 2) @(negedge clk);
        ack = !sda_bus;
        repeat (HP - HP / 2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic ack_m, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp(); scl_m = 1'b1;
            repeat (HP / 2) @(negedge clk);
            b[i] = sda_bus;
            repeat (HP - HP / 2) @(negedge clk);
            scl_m = 1'b0;
        end
        sda_m = ack_m; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; sda_m = 1'b1;
    endtask

    task automatic send_ack(input logic [7:0] b, input string req);
        bit a;
        send_byte(b, a);
        chk(a, req, a, 1);
    endtask

    // reads n bytes from the tracked pointer; time bytes expected from snap_seed
    task automatic rd_body(input int n, input int snap_seed);
        logic [7:0] got;
        logic [7:0] exp;
        for (int k = 0; k < n; k++) begin
            recv_byte((k == n - 1) ? 1'b1 : 1'b0, got);
            if (ptr_m < TB) begin
                exp = live_byte(snap_seed, ptr_m);
                chk(got == exp, "R7 snapshot byte", got, exp);
            end else begin
                exp = exp_mem[ptr_m];
                chk(got == exp, "R6 register file byte", got, exp);
            end
            ptr_m = nxt(ptr_m);
        end
    endtask

    task automatic write_data(input logic [7:0] d);
        send_ack(d, "R3 data ack");
        exp_mem[ptr_m] = d;
        ptr_m = nxt(ptr_m);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        send_ack(8'hD0, "R1 write address ack");
        send_ack(p, "R2 pointer ack");
        ptr_m = (p > 8'(NREGS - 1)) ? 0 : int'(p);
    endtask

    task automatic check_mem(input string req);
        for (int a = 0; a < NREGS; a++) chk(mem[a] == exp_mem[a], req, mem[a], exp_mem[a]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int wc;
        bit a;
        logic [7:0] got;
        for (int i = 0; i < NREGS; i++) begin
            mem[i] = '0;
            exp_mem[i] = '0;
        end
        set_live(1);
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(sda_pull == 1'b0, "R10 reset sda", sda_pull, 0);
        chk(wr_en == 1'b0, "R10 reset strobe", wr_en, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_pull == 1'b0, "R10 after reset sda", sda_pull, 0);

        // R2 R3: full sweep write from pointer 00h, all 17 bytes
        bus_start();
        set_ptr(8'h00);
        for (int k = 0; k < NREGS; k++) write_data(8'(k * 37 + 5));
        bus_stop();
        check_mem("R3 sweep write");
        chk(wr_count == NREGS, "R3 strobe count", wr_count, NREGS);

        // R4: write wraps from 10h to 00h
        bus_start();
        set_ptr(8'h0F);
        write_data(8'hA1);
        write_data(8'hA2);
        write_data(8'hA3);
        bus_stop();
        check_mem("R4 write wrap");

        // R5: read continues at pointer 01h left by last write; R8 release after NACK
        set_live(1);
        bus_start();
        send_ack(8'hD1, "R1 read address ack");
        rd_body(3, 1);
        chk(sda_pull == 1'b0, "R8 released after nack", sda_pull, 0);
        hp(); scl_m = 1'b1;
        repeat (HP / 2) @(negedge clk);
        chk(sda_bus == 1'b1, "R8 idle extra clock", sda_bus, 1);
        repeat (HP - HP / 2) @(negedge clk);
        scl_m = 1'b0;
        bus_stop();

        // R7: snapshot held across a read while live time changes
        set_live(2);
        bus_start();
        set_ptr(8'h00);
        bus_start();
        send_ack(8'hD1, "R1 read address ack");
        set_live(3);
        rd_body(9, 2);
        bus_stop();
        // R7: new START takes a fresh snapshot
        bus_start();
        set_ptr(8'h02);
        bus_stop();
        bus_start();
        send_ack(8'hD1, "R1 read address ack");
        rd_body(2, 3);
        bus_stop();

        // R7 R4: snapshot taken at pointer wrap to 00h
        set_live(4);
        bus_start();
        set_ptr(8'h10);
        bus_start();
        set_live(5);
        send_ack(8'hD1, "R1 read address ack");
        rd_body(2, 5);
        bus_stop();

        // R2: pointer above 10h loads 00h
        bus_start();
        set_ptr(8'h1F);
        write_data(8'h55);
        bus_stop();
        check_mem("R2 out-of-range pointer");

        // R5 R6 R4: read sweep from every start pointer
        set_live(6);
        for (int p = 0; p < NREGS; p++) begin
            bus_start();
            set_ptr(8'(p));
            bus_start();
            send_ack(8'hD1, "R1 read address ack");
            rd_body(2, 6);
            bus_stop();
        end

        // R1: wrong addresses are ignored
        wc = wr_count;
        bus_start();
        send_byte(8'hA0, a);
        chk(!a, "R1 foreign address nack", a, 0);
        send_byte(8'h00, a);
        chk(!a, "R1 ignored byte nack", a, 0);
        send_byte(8'h77, a);
        chk(!a, "R1 ignored byte nack", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'hD3, a);
        chk(!a, "R1 near-miss address nack", a, 0);
        recv_byte(1'b1, got);
        chk(got == 8'hFF, "R1 no drive after nack", got, 8'hFF);
        bus_stop();
        chk(wr_count == wc, "R1 no strobes", wr_count, wc);

        // R9: SCL held low past the timeout
        wc = wr_count;
        bus_start();
        send_ack(8'hD0, "R1 write address ack");
        repeat (TO + 100) @(negedge clk);
        chk(sda_pull == 1'b0, "R9 released after timeout", sda_pull, 0);
        send_byte(8'h03, a);
        chk(!a, "R9 ignored after timeout", a, 0);
        send_byte(8'h99, a);
        chk(!a, "R9 ignored after timeout", a, 0);
        chk(wr_count == wc, "R9 no strobes after timeout", wr_count, wc);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a);
        chk(a, "R9 new START accepted", a, 1);
        bus_stop();
        check_mem("R9 register file intact");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule